// File: doc/BRIEF.md
# Write-Allocate Second-Level Cache Access Controller

This block makes the accept-or-refuse decision for a shared second-level cache that uses write-back for hits and, by default, write-allocate for write misses. Each cycle it may take one read, atomic read or write request. It looks the block up in a set-associative tag store and in a small table of outstanding misses. It then reports in the same cycle whether the request hit, missed, or could not be taken. A refused request must be retried by the requester.

Accepted misses place downstream requests into an internal miss queue. A single write miss under write-allocate may place up to three of them in one cycle. These are the write itself, a line fill read, and the write-back of a dirty victim. The queue is drained one entry per cycle by the lower memory through a pop input. A fill input tells the block that a line's data has arrived. This frees the outstanding-miss entry and makes the reserved line usable. A configuration input switches write misses to plain forwarding without allocation.

Top module: `wac_l2_ctrl`

## Requirements
- R1: A write that finds its line VALID or MODIFIED returns HIT (status code 0), raises no event and enqueues nothing. The line becomes MODIFIED, so its later eviction enqueues a write-back.
- R2: With allocation on, a write miss is taken only when at least three queue slots are free. Otherwise it returns refusal (status code 2) and enqueues nothing.
- R3: A read miss or allocating write miss needs one of two conditions. Either the block is already outstanding and its entry holds fewer than 2 merged requests, or it is not outstanding, one of the 4 outstanding-miss entries is free and the queue is not full. A request that meets neither is refused. A merged request returns MISS (status code 1) and enqueues no read.
- R4: An allocating write miss enqueues, in this order, the write (kind 0), the fill read (kind 1, only when the block was not already outstanding) and the victim write-back (kind 2, only when the victim is MODIFIED). The queue hands entries out in that order.
- R5: The read event pulses only for demand reads. The fill read issued for an allocating write never raises it.
- R6: With allocation off, a write miss needs one free slot. It enqueues only the write, returns MISS and leaves the tag store unchanged, so a later read of that block still misses.
- R7: A read miss needs two free slots. It enqueues a fill read, followed by a write-back of the victim only if the victim is MODIFIED. A clean victim causes no write-back.
- R8: An atomic read that hits returns HIT and marks the line MODIFIED. A plain read hit leaves the line state unchanged.
- R9: The write, read and write-back events are high only in the cycle of the request that enqueues the matching entry.
- R10: After reset, every line is INVALID, no miss is outstanding and the queue is empty.
- R11: The victim is the lowest-numbered INVALID way if one exists. Otherwise it is the least recently used way that is not awaiting a fill. If every way in the set awaits a fill, the request is refused.
- R12: A fill for an outstanding block turns its reserved line VALID and frees its outstanding-miss entry. A read of that block then hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_write_alloc | input | 1 | 1 = allocate on write miss, 0 = forward write only |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_atomic | input | 1 | Read is an atomic read-modify-write |
| req_addr | input | ADDR_W | Byte address of the request |
| resp_valid | output | 1 | Status is meaningful (same cycle as request) |
| resp_status | output | 2 | 0 hit, 1 miss, 2 refused |
| ev_write_sent | output | 1 | A write was enqueued this cycle |
| ev_read_sent | output | 1 | A demand fill read was enqueued this cycle |
| ev_wback_sent | output | 1 | A victim write-back was enqueued this cycle |
| fill_valid | input | 1 | Line data for fill_blk has arrived |
| fill_blk | input | BLK_W | Block address of the completed fill |
| mq_valid | output | 1 | Miss queue holds an entry |
| mq_kind | output | 2 | Head entry kind: 0 write, 1 read, 2 write-back |
| mq_blk | output | BLK_W | Head entry block address |
| mq_pop | input | 1 | Remove the head entry |

## Verification
The two functions that meet in one cycle are the forwarding of a write miss and the eviction of a dirty victim, together with the fill read between them. The bench provokes this by dirtying a line with a write hit and then installing a second block in the same set, so that the dirty line becomes least recently used. A write miss to a third block of that set then follows. The result is judged by the event pattern in the request cycle (write and write-back high, read low) and by popping the queue, which must yield the write, then the fill read, then the dirty block's write-back.

// File: rtl/wac_pkg.sv
// Shared encodings for the write-allocate cache controller.
// Assumes nothing beyond IEEE 1800-2017 enum semantics.
package wac_pkg;
    typedef enum logic [1:0] {
        ST_HIT   = 2'd0,
        ST_MISS  = 2'd1,
        ST_RFAIL = 2'd2
    } acc_status_e;

    typedef enum logic [1:0] {
        LN_INVALID  = 2'd0,
        LN_RESERVED = 2'd1,
        LN_VALID    = 2'd2,
        LN_MODIFIED = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        DQ_WRITE = 2'd0,
        DQ_READ  = 2'd1,
        DQ_WBACK = 2'd2
    } dq_kind_e;

    localparam int PUSH_SLOTS = 3;
endpackage

// File: rtl/wac_tag_store.sv
// Set-associative tag and line-state store with per-set age-based LRU.
// Looks up one set per cycle, proposes a victim, applies one line write
// (which also touches LRU) and one fill completion per cycle.
// Assumes WAYS >= 2 and that ages within a set are a permutation.
module wac_tag_store
    import wac_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  lk_set,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     hit,
    output logic [$clog2(WAYS)-1:0]  hit_way,
    output line_state_e              hit_state,
    output logic                     vic_ok,
    output logic [$clog2(WAYS)-1:0]  vic_way,
    output line_state_e              vic_state,
    output logic [TAG_W-1:0]         vic_tag,
    input  logic                     wr_en,
    input  logic [$clog2(WAYS)-1:0]  wr_way,
    input  logic [TAG_W-1:0]         wr_tag,
    input  line_state_e              wr_state,
    input  logic                     fl_en,
    input  logic [$clog2(SETS)-1:0]  fl_set,
    input  logic [TAG_W-1:0]         fl_tag
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int AGE_W = WAY_W;

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    line_state_e      st_q  [SETS][WAYS];
    logic [AGE_W-1:0] age_q [SETS][WAYS];

    // Tag match against non-invalid lines of the looked-up set.
    always_comb begin
        hit       = 1'b0;
        hit_way   = '0;
        hit_state = LN_INVALID;
        for (int w = 0; w < WAYS; w++) begin
            if (st_q[lk_set][w] != LN_INVALID && tag_q[lk_set][w] == lk_tag && !hit) begin
                hit       = 1'b1;
                hit_way   = WAY_W'(w);
                hit_state = st_q[lk_set][w];
            end
        end
    end

    // Victim choice: first invalid way, else oldest way not awaiting a fill.
    always_comb begin
        logic             found_inv;
        logic [AGE_W-1:0] best_age;
        found_inv = 1'b0;
        best_age  = '0;
        vic_ok    = 1'b0;
        vic_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (st_q[lk_set][w] == LN_INVALID && !found_inv) begin
                found_inv = 1'b1;
                vic_ok    = 1'b1;
                vic_way   = WAY_W'(w);
            end
        end
        if (!found_inv) begin
            for (int w = 0; w < WAYS; w++) begin
                if (st_q[lk_set][w] != LN_RESERVED && (!vic_ok || age_q[lk_set][w] > best_age)) begin
                    vic_ok   = 1'b1;
                    vic_way  = WAY_W'(w);
                    best_age = age_q[lk_set][w];
                end
            end
        end
        vic_state = st_q[lk_set][vic_way];
        vic_tag   = tag_q[lk_set][vic_way];
    end

    // Line state, tag and LRU update; fill completion applied last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    st_q[s][w]  <= LN_INVALID;
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            if (wr_en) begin
                tag_q[lk_set][wr_way] <= wr_tag;
                st_q[lk_set][wr_way]  <= wr_state;
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == wr_way)
                        age_q[lk_set][w] <= '0;
                    else if (age_q[lk_set][w] < age_q[lk_set][wr_way])
                        age_q[lk_set][w] <= age_q[lk_set][w] + 1'b1;
                end
            end
            if (fl_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (st_q[fl_set][w] == LN_RESERVED && tag_q[fl_set][w] == fl_tag)
                        st_q[fl_set][w] <= LN_VALID;
                end
            end
        end
    end
endmodule

// File: rtl/wac_miss_table.sv
// Outstanding-miss table: a block-address CAM with per-entry merge counts.
// Reports whether a looked-up block can take one more request, registers
// an accepted request (merge or allocate) and frees an entry on fill.
// Assumes the caller only asserts take_en when lk_room is high.
module wac_miss_table #(
    parameter int ENTRIES   = 4,
    parameter int MERGE_MAX = 2,
    parameter int BLK_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] lk_blk,
    output logic             lk_hit,
    output logic             lk_room,
    input  logic             take_en,
    input  logic             rel_en,
    input  logic [BLK_W-1:0] rel_blk
);
    localparam int CNT_W = $clog2(MERGE_MAX + 1);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic             vld_q [ENTRIES];
    logic [BLK_W-1:0] blk_q [ENTRIES];
    logic [CNT_W-1:0] cnt_q [ENTRIES];

    logic [IDX_W-1:0] hit_idx, free_idx, rel_idx;
    logic             free_any, rel_hit;

    // CAM match for lookup and release, plus first free entry.
    always_comb begin
        lk_hit   = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        rel_hit  = 1'b0;
        rel_idx  = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (vld_q[e] && blk_q[e] == lk_blk && !lk_hit) begin
                lk_hit  = 1'b1;
                hit_idx = IDX_W'(e);
            end
            if (!vld_q[e] && !free_any) begin
                free_any = 1'b1;
                free_idx = IDX_W'(e);
            end
            if (vld_q[e] && blk_q[e] == rel_blk && !rel_hit) begin
                rel_hit = 1'b1;
                rel_idx = IDX_W'(e);
            end
        end
        lk_room = lk_hit ? (cnt_q[hit_idx] < CNT_W'(MERGE_MAX)) : free_any;
    end

    // Merge, allocate and release of entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                vld_q[e] <= 1'b0;
                blk_q[e] <= '0;
                cnt_q[e] <= '0;
            end
        end else begin
            if (take_en) begin
                if (lk_hit) begin
                    cnt_q[hit_idx] <= cnt_q[hit_idx] + 1'b1;
                end else if (free_any) begin
                    vld_q[free_idx] <= 1'b1;
                    blk_q[free_idx] <= lk_blk;
                    cnt_q[free_idx] <= CNT_W'(1);
                end
            end
            if (rel_en && rel_hit) begin
                vld_q[rel_idx] <= 1'b0;
                cnt_q[rel_idx] <= '0;
            end
        end
    end
endmodule

// File: rtl/wac_miss_fifo.sv
// Miss queue taking up to SLOTS ordered pushes and one pop per cycle.
// Valid push slots are packed in slot order behind the tail.
// Assumes DEPTH is a power of two and the caller never overfills it.
module wac_miss_fifo #(
    parameter int DEPTH = 8,
    parameter int BLK_W = 11,
    parameter int SLOTS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SLOTS-1:0]           push_vld,
    input  logic [SLOTS-1:0][1:0]      push_kind,
    input  logic [SLOTS-1:0][BLK_W-1:0] push_blk,
    input  logic                       pop,
    output logic                       head_vld,
    output logic [1:0]                 head_kind,
    output logic [BLK_W-1:0]           head_blk,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [1:0]       kind_q [DEPTH];
    logic [BLK_W-1:0] blk_q  [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [PTR_W-1:0] slot_ptr [SLOTS];
    logic [CNT_W-1:0] n_push;
    logic             do_pop;

    // Position of each valid push slot behind the tail, and push count.
    always_comb begin
        n_push = '0;
        for (int i = 0; i < SLOTS; i++) begin
            slot_ptr[i] = wr_ptr + PTR_W'(n_push);
            if (push_vld[i])
                n_push = n_push + 1'b1;
        end
    end

    assign do_pop    = pop && (count != '0);
    assign head_vld  = (count != '0);
    assign head_kind = kind_q[rd_ptr];
    assign head_blk  = blk_q[rd_ptr];

    // Entry storage writes (data needs no reset).
    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (push_vld[i]) begin
                kind_q[slot_ptr[i]] <= push_kind[i];
                blk_q[slot_ptr[i]]  <= push_blk[i];
            end
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(n_push);
            rd_ptr <= rd_ptr + PTR_W'(do_pop);
            count  <= count + n_push - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/wac_l2_ctrl.sv
// Access decision logic of a write-back, write-allocate second-level cache.
// Per cycle: one request is classified HIT/MISS/refused against the tag
// store, outstanding-miss table and miss-queue occupancy; accepted misses
// push ordered downstream requests. Response and events are combinational
// in the request cycle; all state changes at the following edge.
// Assumes the requester retries refused requests and that a fill never
// targets the same set as a request in the same cycle.
module wac_l2_ctrl
    import wac_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int LINE_BYTES   = 32,
    parameter int SETS         = 4,
    parameter int WAYS         = 2,
    parameter int MSHR_ENTRIES = 4,
    parameter int MSHR_MERGE   = 2,
    parameter int MQ_DEPTH     = 8,
    localparam int OFF_W       = $clog2(LINE_BYTES),
    localparam int BLK_W       = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_write_alloc,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_atomic,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [1:0]        resp_status,
    output logic              ev_write_sent,
    output logic              ev_read_sent,
    output logic              ev_wback_sent,
    input  logic              fill_valid,
    input  logic [BLK_W-1:0]  fill_blk,
    output logic              mq_valid,
    output logic [1:0]        mq_kind,
    output logic [BLK_W-1:0]  mq_blk,
    input  logic              mq_pop
);
    localparam int SET_W     = $clog2(SETS);
    localparam int TAG_W     = BLK_W - SET_W;
    localparam int WAY_W     = $clog2(WAYS);
    localparam int MQ_CNT_W  = $clog2(MQ_DEPTH + 1);
    localparam int SLOTS     = PUSH_SLOTS;

    logic [BLK_W-1:0] blk;
    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag;

    logic             t_hit, v_ok;
    logic [WAY_W-1:0] t_way, v_way;
    line_state_e      t_state, v_state;
    logic [TAG_W-1:0] v_tag;

    logic             tw_en;
    logic [WAY_W-1:0] tw_way;
    logic [TAG_W-1:0] tw_tag;
    line_state_e      tw_state;

    logic             m_hit, m_room, m_take;

    logic [SLOTS-1:0]            push_vld;
    logic [SLOTS-1:0][1:0]       push_kind;
    logic [SLOTS-1:0][BLK_W-1:0] push_blk;
    logic [MQ_CNT_W-1:0]         q_count;
    logic [MQ_CNT_W-1:0]         free_slots;

    logic        line_ready, mshr_ok, vict_good, wb_needed, rd_needed;
    acc_status_e status;

    assign blk     = req_addr[ADDR_W-1:OFF_W];
    assign set_idx = blk[SET_W-1:0];
    assign tag     = blk[BLK_W-1:SET_W];

    wac_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(set_idx), .lk_tag(tag),
        .hit(t_hit), .hit_way(t_way), .hit_state(t_state),
        .vic_ok(v_ok), .vic_way(v_way), .vic_state(v_state), .vic_tag(v_tag),
        .wr_en(tw_en), .wr_way(tw_way), .wr_tag(tw_tag), .wr_state(tw_state),
        .fl_en(fill_valid), .fl_set(fill_blk[SET_W-1:0]), .fl_tag(fill_blk[BLK_W-1:SET_W])
    );

    wac_miss_table #(.ENTRIES(MSHR_ENTRIES), .MERGE_MAX(MSHR_MERGE), .BLK_W(BLK_W)) u_mshr (
        .clk(clk), .rst_n(rst_n),
        .lk_blk(blk), .lk_hit(m_hit), .lk_room(m_room),
        .take_en(m_take), .rel_en(fill_valid), .rel_blk(fill_blk)
    );

    wac_miss_fifo #(.DEPTH(MQ_DEPTH), .BLK_W(BLK_W), .SLOTS(SLOTS)) u_mq (
        .clk(clk), .rst_n(rst_n),
        .push_vld(push_vld), .push_kind(push_kind), .push_blk(push_blk),
        .pop(mq_pop), .head_vld(mq_valid), .head_kind(mq_kind), .head_blk(mq_blk),
        .count(q_count)
    );

    // Admission inputs derived from lookups and queue occupancy.
    always_comb begin
        free_slots = MQ_CNT_W'(MQ_DEPTH) - q_count;
        line_ready = t_hit && (t_state == LN_VALID || t_state == LN_MODIFIED);
        mshr_ok    = m_hit ? m_room : (m_room && (q_count < MQ_CNT_W'(MQ_DEPTH)));
        vict_good  = t_hit || v_ok;
        wb_needed  = !t_hit && (v_state == LN_MODIFIED);
        rd_needed  = !m_hit;
    end

    // Request classification, downstream pushes and state updates.
    always_comb begin
        status    = ST_HIT;
        push_vld  = '0;
        push_kind[0] = DQ_WRITE;
        push_kind[1] = DQ_READ;
        push_kind[2] = DQ_WBACK;
        push_blk[0]  = blk;
        push_blk[1]  = blk;
        push_blk[2]  = {v_tag, set_idx};
        tw_en     = 1'b0;
        tw_way    = t_way;
        tw_tag    = tag;
        tw_state  = t_state;
        m_take    = 1'b0;
        if (req_valid) begin
            if (line_ready) begin
                tw_en = 1'b1;
                if (req_write || req_atomic)
                    tw_state = LN_MODIFIED;
            end else if (req_write && !cfg_write_alloc) begin
                if (free_slots >= MQ_CNT_W'(1)) begin
                    status      = ST_MISS;
                    push_vld[0] = 1'b1;
                end else begin
                    status = ST_RFAIL;
                end
            end else if ((free_slots >= MQ_CNT_W'(req_write ? 3 : 2)) && mshr_ok && vict_good) begin
                status      = ST_MISS;
                push_vld[0] = req_write;
                push_vld[1] = rd_needed;
                push_vld[2] = wb_needed;
                m_take      = 1'b1;
                if (!t_hit) begin
                    tw_en    = 1'b1;
                    tw_way   = v_way;
                    tw_state = LN_RESERVED;
                end
            end else begin
                status = ST_RFAIL;
            end
        end
    end

    assign resp_valid    = req_valid;
    assign resp_status   = status;
    assign ev_write_sent = push_vld[0];
    assign ev_read_sent  = push_vld[1] && !req_write;
    assign ev_wback_sent = push_vld[2];
endmodule

// File: rtl/wac_l2_ctrl_chk.sv
// Property checker for wac_l2_ctrl, attached by bind below.
// Assumes status codes and queue occupancy as produced by the controller.
module wac_l2_ctrl_chk #(
    parameter int MQ_DEPTH = 8,
    parameter int CNT_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_write_alloc,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       resp_status,
    input logic             ev_write_sent,
    input logic             ev_read_sent,
    input logic             ev_wback_sent,
    input logic             mq_valid,
    input logic             mq_pop,
    input logic [CNT_W-1:0] q_count
);
    AST_HIT_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && resp_status == 2'd0) |-> !(ev_write_sent || ev_read_sent || ev_wback_sent)); // R1

    AST_ALLOC_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && cfg_write_alloc && resp_status == 2'd1) |-> (q_count <= CNT_W'(MQ_DEPTH - 3))); // R2

    AST_REFUSE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && resp_status == 2'd2) |=> (q_count == $past(q_count) - CNT_W'($past(mq_pop && mq_valid)))); // R3

    AST_NO_READ_EVT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> !ev_read_sent); // R5

    AST_NOALLOC_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !cfg_write_alloc) |-> !ev_wback_sent); // R6

    AST_WBACK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wback_sent |-> (req_valid && resp_status == 2'd1)); // R7

    AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(ev_write_sent || ev_read_sent || ev_wback_sent)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(MQ_DEPTH)); // R2
endmodule

bind wac_l2_ctrl wac_l2_ctrl_chk #(.MQ_DEPTH(MQ_DEPTH), .CNT_W(MQ_CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_write_alloc(cfg_write_alloc),
    .req_valid(req_valid), .req_write(req_write), .resp_status(resp_status),
    .ev_write_sent(ev_write_sent), .ev_read_sent(ev_read_sent), .ev_wback_sent(ev_wback_sent),
    .mq_valid(mq_valid), .mq_pop(mq_pop), .q_count(q_count)
);

// File: tb/tb_wac_l2_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_wac_l2_ctrl;
    localparam int ADDR_W = 16;
    localparam int BLK_W  = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_write_alloc = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              req_atomic = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              resp_valid;
    logic [1:0]        resp_status;
    logic              ev_write_sent, ev_read_sent, ev_wback_sent;
    logic              fill_valid = 1'b0;
    logic [BLK_W-1:0]  fill_blk = '0;
    logic              mq_valid;
    logic [1:0]        mq_kind;
    logic [BLK_W-1:0]  mq_blk;
    logic              mq_pop = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    wac_l2_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_write_alloc(cfg_write_alloc),
        .req_valid(req_valid), .req_write(req_write), .req_atomic(req_atomic),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_status(resp_status),
        .ev_write_sent(ev_write_sent), .ev_read_sent(ev_read_sent), .ev_wback_sent(ev_wback_sent),
        .fill_valid(fill_valid), .fill_blk(fill_blk),
        .mq_valid(mq_valid), .mq_kind(mq_kind), .mq_blk(mq_blk), .mq_pop(mq_pop)
    );

    localparam logic [1:0] S_HIT = 2'd0, S_MISS = 2'd1, S_FAIL = 2'd2;
    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_WB = 2'd2;

    function automatic logic [BLK_W-1:0] mk(input int t, input int s);
        return {9'(t), 2'(s)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        req_valid = 1'b0; fill_valid = 1'b0; mq_pop = 1'b0; cfg_write_alloc = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One request cycle; ev is {write, read, wback}. Called just after a negedge.
    task automatic access(input bit w, input bit at, input logic [BLK_W-1:0] b,
                          input logic [1:0] exp_st, input logic [2:0] exp_ev, input string req);
        req_valid = 1'b1; req_write = w; req_atomic = at; req_addr = {b, 5'd0};
        #1;
        chk(resp_valid && resp_status == exp_st, req, int'(resp_status), int'(exp_st));
        chk({ev_write_sent, ev_read_sent, ev_wback_sent} == exp_ev, {req, " R9 events"},
            int'({ev_write_sent, ev_read_sent, ev_wback_sent}), int'(exp_ev));
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_atomic = 1'b0;
        #1;
        chk({ev_write_sent, ev_read_sent, ev_wback_sent} == 3'b000, "R9 idle events",
            int'({ev_write_sent, ev_read_sent, ev_wback_sent}), 0);
        @(negedge clk);
    endtask

    task automatic fill(input logic [BLK_W-1:0] b);
        fill_valid = 1'b1; fill_blk = b;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic pop_expect(input logic [1:0] k, input logic [BLK_W-1:0] b, input string req);
        #1;
        chk(mq_valid, {req, " head valid"}, int'(mq_valid), 1);
        chk(mq_kind == k, {req, " kind"}, int'(mq_kind), int'(k));
        chk(mq_blk == b, {req, " block"}, int'(mq_blk), int'(b));
        mq_pop = 1'b1;
        @(negedge clk);
        mq_pop = 1'b0;
    endtask

    task automatic expect_empty(input string req);
        #1;
        chk(!mq_valid, req, int'(mq_valid), 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        apply_reset();
        expect_empty("R10 queue empty after reset");
        access(1'b0, 1'b0, mk(1, 0), S_MISS, 3'b010, "R10 lines invalid after reset");
        pop_expect(K_RD, mk(1, 0), "R10 first fill read");
        expect_empty("R10 queue drained");
    endtask

    task automatic t_merge_and_fill();
        apply_reset();
        access(1'b0, 1'b0, mk(1, 0), S_MISS, 3'b010, "R5 demand read raises read event");
        access(1'b0, 1'b0, mk(1, 0), S_MISS, 3'b000, "R3 merge into outstanding entry");
        access(1'b0, 1'b0, mk(1, 0), S_FAIL, 3'b000, "R3 merge limit reached");
        pop_expect(K_RD, mk(1, 0), "R3 single read for merged block");
        expect_empty("R3 no extra read");
        fill(mk(1, 0));
        access(1'b0, 1'b0, mk(1, 0), S_HIT, 3'b000, "R12 fill makes line valid");
    endtask

    task automatic t_alloc_order();
        apply_reset();
        access(1'b0, 1'b0, mk(1, 0), S_MISS, 3'b010, "R7 read miss A");
        pop_expect(K_RD, mk(1, 0), "R7 read A");
        fill(mk(1, 0));
        access(1'b1, 1'b0, mk(1, 0), S_HIT, 3'b000, "R1 write hit");
        expect_empty("R1 write hit enqueues nothing");
        access(1'b0, 1'b0, mk(2, 0), S_MISS, 3'b010, "R11 invalid way used for B");
        pop_expect(K_RD, mk(2, 0), "R7 read B");
        fill(mk(2, 0));
        access(1'b1, 1'b0, mk(3, 0), S_MISS, 3'b101, "R5 allocating write: no read event");
        pop_expect(K_WR, mk(3, 0), "R4 write first");
        pop_expect(K_RD, mk(3, 0), "R4 fill read second");
        pop_expect(K_WB, mk(1, 0), "R4 R11 dirty LRU victim written back third");
        expect_empty("R4 exactly three entries");
    endtask

    task automatic t_no_alloc();
        apply_reset();
        cfg_write_alloc = 1'b0;
        access(1'b1, 1'b0, mk(5, 1), S_MISS, 3'b100, "R6 forwarded write");
        pop_expect(K_WR, mk(5, 1), "R6 write only");
        expect_empty("R6 nothing else queued");
        access(1'b0, 1'b0, mk(5, 1), S_MISS, 3'b010, "R6 block not allocated");
        pop_expect(K_RD, mk(5, 1), "R6 read after forwarded write");
        cfg_write_alloc = 1'b1;
    endtask

    task automatic t_queue_room();
        apply_reset();
        cfg_write_alloc = 1'b0;
        for (int i = 0; i < 6; i++)
            access(1'b1, 1'b0, mk(10 + i, 2), S_MISS, 3'b100, "R6 fill queue");
        cfg_write_alloc = 1'b1;
        access(1'b1, 1'b0, mk(20, 3), S_FAIL, 3'b000, "R2 two free slots refuse allocating write");
        access(1'b0, 1'b0, mk(20, 3), S_MISS, 3'b010, "R7 two free slots take read miss");
        access(1'b0, 1'b0, mk(21, 1), S_FAIL, 3'b000, "R7 one free slot refuses read miss");
        cfg_write_alloc = 1'b0;
        access(1'b1, 1'b0, mk(22, 1), S_MISS, 3'b100, "R6 one free slot takes forwarded write");
        access(1'b1, 1'b0, mk(23, 1), S_FAIL, 3'b000, "R6 full queue refuses write");
        cfg_write_alloc = 1'b1;
        for (int i = 0; i < 6; i++)
            pop_expect(K_WR, mk(10 + i, 2), "R2 queued writes in order");
        pop_expect(K_RD, mk(20, 3), "R7 read after writes");
        pop_expect(K_WR, mk(22, 1), "R6 last write");
        expect_empty("R2 refused requests left no entry");
    endtask

    task automatic t_mshr_full();
        apply_reset();
        for (int s = 0; s < 4; s++)
            access(1'b0, 1'b0, mk(1, s), S_MISS, 3'b010, "R3 allocate outstanding entry");
        for (int s = 0; s < 4; s++)
            pop_expect(K_RD, mk(1, s), "R3 fill reads");
        access(1'b0, 1'b0, mk(2, 0), S_FAIL, 3'b000, "R3 no free entry refuses read");
        access(1'b1, 1'b0, mk(2, 1), S_FAIL, 3'b000, "R3 no free entry refuses allocating write");
        expect_empty("R3 refused requests queue nothing");
        fill(mk(1, 0));
        access(1'b0, 1'b0, mk(2, 0), S_MISS, 3'b010, "R12 fill frees entry");
        pop_expect(K_RD, mk(2, 0), "R12 read after free");
    endtask

    task automatic t_all_reserved();
        apply_reset();
        access(1'b0, 1'b0, mk(1, 0), S_MISS, 3'b010, "R11 first reserve");
        access(1'b0, 1'b0, mk(2, 0), S_MISS, 3'b010, "R11 second reserve");
        pop_expect(K_RD, mk(1, 0), "R11 read one");
        pop_expect(K_RD, mk(2, 0), "R11 read two");
        access(1'b0, 1'b0, mk(3, 0), S_FAIL, 3'b000, "R11 all ways awaiting fill");
        expect_empty("R11 nothing queued");
    endtask

    task automatic t_atomic();
        apply_reset();
        access(1'b0, 1'b0, mk(1, 0), S_MISS, 3'b010, "R8 read X");
        pop_expect(K_RD, mk(1, 0), "R8 read X queued");
        fill(mk(1, 0));
        access(1'b0, 1'b1, mk(1, 0), S_HIT, 3'b000, "R8 atomic hit");
        access(1'b0, 1'b0, mk(2, 0), S_MISS, 3'b010, "R8 read Y");
        pop_expect(K_RD, mk(2, 0), "R8 read Y queued");
        fill(mk(2, 0));
        access(1'b0, 1'b0, mk(3, 0), S_MISS, 3'b011, "R8 atomic-dirtied victim");
        pop_expect(K_RD, mk(3, 0), "R7 fill read before write-back");
        pop_expect(K_WB, mk(1, 0), "R8 write-back of atomic line");
        fill(mk(3, 0));
        access(1'b0, 1'b0, mk(2, 0), S_HIT, 3'b000, "R8 plain read hit");
        access(1'b0, 1'b0, mk(4, 0), S_MISS, 3'b010, "R7 clean victim no write-back");
        pop_expect(K_RD, mk(4, 0), "R7 read only");
        expect_empty("R7 no write-back queued");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_merge_and_fill();
        t_alloc_order();
        t_no_alloc();
        t_queue_room();
        t_mshr_full();
        t_all_reserved();
        t_atomic();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule